// File: doc/BRIEF.md
# Clock Output Stop and Gating Stage

This block sits between the divided internal clocks of a board clock generator and its output pads. For every output it decides, on each tick of a fast sampling clock, whether the output follows its internal source clock, rests low or leaves its pad undriven. It applies three controls:

- an active-low stop input for the processor clocks;
- an active-low stop input for the bus clocks, which exists only when a latched strap turns the shared reference pad into an input;
- per-output enable fields from the register bank, together with a two-bit output mode that can release every pad at once.

Each source clock is presented as a level that is sampled by `clk`. A gated output changes its run state only while its source is low. A stop therefore never cuts a high phase short, and a released output comes back with a full high phase. One output in each of the processor, bus and memory groups ignores every stop. The stop inputs are asynchronous and are synchronized inside the block.

Top module: `clkout_gate`

## Requirements
- R1: While `rst_n` is low, every bit of `clk_o` and `oe_o` is 0. The bit map of `clk_o` and `oe_o` is: 0 is the free processor clock, 1 is the stoppable processor clock, 2 is the free bus clock, 3 to 7 are the stoppable bus clocks, 8 is the free memory clock, 9 to 20 are the memory clocks in three groups of four (group g covers 9+4g to 12+4g), 21 is the shared reference pad, 22 is the second reference, 23 is the interrupt-controller reference, 24 is the 48 MHz clock and 25 is the 24 MHz clock.
- R2: An output that no stop acts on and whose enable is 1 equals its source as sampled at the previous `clk` edge, once its source has been low at one edge since reset.
- R3: When `cpu_stop_n_i` is held low, the stoppable processor clock completes its current high phase and then rests low. The stop reaches the gate `SYNC_STAGES` edges after it is sampled and acts at the first edge where the source is low.
- R4: `cpu_stop_n_i` has no effect on the free processor clock, on the bus, memory and reference outputs, or on the 48 MHz and 24 MHz outputs.
- R5: With `mode_strap_i` = 1, output 21 carries the reference source with its enable set to 1, and `ref0_pin_i` does not stop any bus clock.
- R6: With `mode_strap_i` = 0, output 21 is held low with `oe_o[21]` = 0. A low level on `ref0_pin_i` stops bus clocks 3 to 7 in the same way that R3 stops the processor clock, while output 2 keeps running.
- R7: An enable bit of 0 holds its output low while the pad stays driven. The enable bits are mapped as follows: `cpu_en_i[c]` drives output c; `pci_en_i[p]` drives output 2+p; `sdr_grp_en_i[g]` drives the four clocks of memory group g; `misc_en_i` bits 0 to 4 drive outputs 21 to 25. Output 8 has no enable.
- R8: `out_mode_i` = 2'b11 drives every `oe_o` bit to 0 at the next edge. Values 2'b00, 2'b01 and 2'b10 drive every bit to 1, except bit 21, which follows `mode_strap_i`.
- R9: A gated output rises only one edge after its source is sampled rising. It falls only one edge after its source is sampled falling, so no shortened high or low phase appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than every source |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_src_i | input | 1 | Processor source clock level |
| pci_src_i | input | 1 | Bus source clock level |
| sdr_src_i | input | 1 | Memory source clock level |
| ref_src_i | input | 1 | Reference source clock level |
| usb_src_i | input | 1 | 48 MHz source clock level |
| sio_src_i | input | 1 | 24 MHz source clock level |
| cpu_stop_n_i | input | 1 | Asynchronous active-low processor stop |
| ref0_pin_i | input | 1 | Shared pad read as the active-low bus stop when the strap is 0 |
| mode_strap_i | input | 1 | Latched strap: 1 selects reference output, 0 selects stop input |
| out_mode_i | input | 2 | Output mode: 00 normal, 10 spread, 01 reserved, 11 all pads released |
| cpu_en_i | input | N_CPU | Processor output enables |
| pci_en_i | input | N_PCI | Bus output enables |
| sdr_grp_en_i | input | SDR_GRPS | Memory group enables |
| misc_en_i | input | 5 | Reference, 48 MHz and 24 MHz enables |
| clk_o | output | NOUT | Gated clock value per output |
| oe_o | output | NOUT | Pad drive enable per output |

## Verification
The hardest case to reach is a stop that arrives while a source is high and is released while the source is high or low. A stop that lands mid-phase is where a runt pulse or a truncated high phase would appear. The bench asserts and releases each stop at several offsets against the source phases, which run at periods of four and six sampling cycles. A cycle-accurate model checks every output on every edge. That model includes the synchronizer depth and the rule that the run state changes only while the source is low.

// File: rtl/clkout_gate_pkg.sv
package clkout_gate_pkg;

   // Output mode field from the register bank
   typedef enum logic [1:0] {
      OMODE_NORMAL = 2'b00,
      OMODE_RSVD   = 2'b01,
      OMODE_SPREAD = 2'b10,
      OMODE_HIZ    = 2'b11
   } omode_e;

   // Fixed outputs after the memory block: shared reference, second
   // reference, interrupt-controller reference, 48 MHz, 24 MHz
   localparam int MISC_CNT   = 5;
   localparam int MI_REF0    = 0;
   localparam int MI_REF1    = 1;
   localparam int MI_IOREF   = 2;
   localparam int MI_USB     = 3;
   localparam int MI_SIO     = 4;

endpackage

// File: rtl/clkout_sync.sv
module clkout_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("clkout_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shift_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shift_q <= '0;
      else        shift_q <= {shift_q[STAGES-2:0], d_i};
   end

   assign q_o = shift_q[STAGES-1];

endmodule

// File: rtl/clkout_gate_cell.sv
module clkout_gate_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic stop_i,
   input  logic en_i,
   output logic q_o
);

   // Run state only moves while the source is low, so the output
   // never loses part of a high phase and never gains a runt.
   logic run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         q_o   <= 1'b0;
      end else begin
         q_o <= src_i & run_q;
         if (!src_i) run_q <= en_i & ~stop_i;
      end
   end

endmodule

// File: rtl/clkout_gate.sv
module clkout_gate
   import clkout_gate_pkg::*;
#(
   parameter  int N_CPU       = 2,
   parameter  int N_PCI       = 6,
   parameter  int SDR_GRPS    = 3,
   parameter  int SDR_PER_GRP = 4,
   parameter  int SYNC_STAGES = 2,
   localparam int PCI_BASE    = N_CPU,
   localparam int SDRF_IDX    = PCI_BASE + N_PCI,
   localparam int SDR_BASE    = SDRF_IDX + 1,
   localparam int MISC_BASE   = SDR_BASE + SDR_GRPS * SDR_PER_GRP,
   localparam int NOUT        = MISC_BASE + MISC_CNT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_src_i,
   input  logic                pci_src_i,
   input  logic                sdr_src_i,
   input  logic                ref_src_i,
   input  logic                usb_src_i,
   input  logic                sio_src_i,
   input  logic                cpu_stop_n_i,
   input  logic                ref0_pin_i,
   input  logic                mode_strap_i,
   input  logic [1:0]          out_mode_i,
   input  logic [N_CPU-1:0]    cpu_en_i,
   input  logic [N_PCI-1:0]    pci_en_i,
   input  logic [SDR_GRPS-1:0] sdr_grp_en_i,
   input  logic [MISC_CNT-1:0] misc_en_i,
   output logic [NOUT-1:0]     clk_o,
   output logic [NOUT-1:0]     oe_o
);

   if (N_CPU < 2) begin : g_bad_cpu
      $error("clkout_gate: N_CPU needs one free and one stoppable output");
   end
   if (N_PCI < 2) begin : g_bad_pci
      $error("clkout_gate: N_PCI needs one free and one stoppable output");
   end
   if (SDR_GRPS < 1 || SDR_PER_GRP < 1) begin : g_bad_sdr
      $error("clkout_gate: memory group shape must be non-empty");
   end

   // Stop request synchronizers
   logic cpu_stop_s;
   logic pci_stop_s;
   logic pci_stop_raw;

   // The shared pad acts as a stop input only when the strap selects it
   assign pci_stop_raw = ~mode_strap_i & ~ref0_pin_i;

   clkout_sync #(.STAGES(SYNC_STAGES)) u_cpu_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (~cpu_stop_n_i),
      .q_o   (cpu_stop_s)
   );

   clkout_sync #(.STAGES(SYNC_STAGES)) u_pci_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pci_stop_raw),
      .q_o   (pci_stop_s)
   );

   // Per-output source, enable and stop selection
   logic [NOUT-1:0] src_v;
   logic [NOUT-1:0] en_v;
   logic [NOUT-1:0] stop_v;

   always_comb begin
      src_v  = '0;
      en_v   = '0;
      stop_v = '0;
      for (int c = 0; c < N_CPU; c++) begin
         src_v[c]  = cpu_src_i;
         en_v[c]   = cpu_en_i[c];
         stop_v[c] = (c != 0) & cpu_stop_s;
      end
      for (int p = 0; p < N_PCI; p++) begin
         src_v[PCI_BASE+p]  = pci_src_i;
         en_v[PCI_BASE+p]   = pci_en_i[p];
         stop_v[PCI_BASE+p] = (p != 0) & pci_stop_s;
      end
      src_v[SDRF_IDX] = sdr_src_i;
      en_v[SDRF_IDX]  = 1'b1;
      for (int g = 0; g < SDR_GRPS; g++) begin
         for (int b = 0; b < SDR_PER_GRP; b++) begin
            src_v[SDR_BASE+g*SDR_PER_GRP+b] = sdr_src_i;
            en_v[SDR_BASE+g*SDR_PER_GRP+b]  = sdr_grp_en_i[g];
         end
      end
      src_v[MISC_BASE+MI_REF0]  = ref_src_i;
      src_v[MISC_BASE+MI_REF1]  = ref_src_i;
      src_v[MISC_BASE+MI_IOREF] = ref_src_i;
      src_v[MISC_BASE+MI_USB]   = usb_src_i;
      src_v[MISC_BASE+MI_SIO]   = sio_src_i;
      for (int m = 0; m < MISC_CNT; m++) begin
         en_v[MISC_BASE+m] = misc_en_i[m];
      end
      en_v[MISC_BASE+MI_REF0] = misc_en_i[MI_REF0] & mode_strap_i;
   end

   // One gate cell per output
   for (genvar k = 0; k < NOUT; k++) begin : g_out
      clkout_gate_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .src_i  (src_v[k]),
         .stop_i (stop_v[k]),
         .en_i   (en_v[k]),
         .q_o    (clk_o[k])
      );
   end

   // Pad drive enables, registered to line up with the clock values
   logic [NOUT-1:0] oe_q;
   logic            hiz;

   assign hiz = (omode_e'(out_mode_i) == OMODE_HIZ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q <= '0;
      end else if (hiz) begin
         oe_q <= '0;
      end else begin
         oe_q                    <= '1;
         oe_q[MISC_BASE+MI_REF0] <= mode_strap_i;
      end
   end

   assign oe_o = oe_q;

endmodule

// File: rtl/clkout_gate_chk.sv
module clkout_gate_chk #(
   parameter int N_CPU       = 2,
   parameter int N_PCI       = 6,
   parameter int SDR_GRPS    = 3,
   parameter int SDR_PER_GRP = 4,
   parameter int NOUT        = 26
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cpu_src_i,
   input logic            sdr_src_i,
   input logic            mode_strap_i,
   input logic [1:0]      out_mode_i,
   input logic [NOUT-1:0] clk_o,
   input logic [NOUT-1:0] oe_o
);

   localparam int CPU_GATED = 1;
   localparam int SDRF      = N_CPU + N_PCI;
   localparam int REF0      = SDRF + 1 + SDR_GRPS * SDR_PER_GRP;

   // R2: free memory clock tracks its source one edge later
   p_free_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(rst_n, 2) && !$past(sdr_src_i, 2)
      |-> clk_o[SDRF] == $past(sdr_src_i));

   // R9: a high phase continues while the source is still high
   p_no_runt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(clk_o[CPU_GATED]) && $past(cpu_src_i)
      |-> clk_o[CPU_GATED]);

   // R9: the gated output rises only on a source rising edge
   p_full_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $rose(clk_o[CPU_GATED])
      |-> $past(cpu_src_i) && !$past(cpu_src_i, 2));

   // R8: all-release mode drops every pad enable
   p_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_mode_i == 2'b11 |=> oe_o == '0);

   // R6: strap low turns the shared pad into an input held quiet
   p_ref0_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_strap_i |=> !oe_o[REF0] && !clk_o[REF0]);

endmodule

bind clkout_gate clkout_gate_chk #(
   .N_CPU       (N_CPU),
   .N_PCI       (N_PCI),
   .SDR_GRPS    (SDR_GRPS),
   .SDR_PER_GRP (SDR_PER_GRP),
   .NOUT        (NOUT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_src_i    (cpu_src_i),
   .sdr_src_i    (sdr_src_i),
   .mode_strap_i (mode_strap_i),
   .out_mode_i   (out_mode_i),
   .clk_o        (clk_o),
   .oe_o         (oe_o)
);

// File: tb/clkout_gate_test.sv
`timescale 1ns/1ps
module clkout_gate_test;

   localparam int NOUT = 26;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cpu_src_i = 0, pci_src_i = 0, sdr_src_i = 0;
   logic            ref_src_i = 0, usb_src_i = 0, sio_src_i = 0;
   logic            cpu_stop_n_i = 1'b1;
   logic            ref0_pin_i = 1'b1;
   logic            mode_strap_i = 1'b1;
   logic [1:0]      out_mode_i = 2'b00;
   logic [1:0]      cpu_en_i = '1;
   logic [5:0]      pci_en_i = '1;
   logic [2:0]      sdr_grp_en_i = '1;
   logic [4:0]      misc_en_i = '1;
   logic [NOUT-1:0] clk_o;
   logic [NOUT-1:0] oe_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc_n    = 0;
   bit done     = 0;

   clkout_gate uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_src_i(cpu_src_i), .pci_src_i(pci_src_i), .sdr_src_i(sdr_src_i),
      .ref_src_i(ref_src_i), .usb_src_i(usb_src_i), .sio_src_i(sio_src_i),
      .cpu_stop_n_i(cpu_stop_n_i), .ref0_pin_i(ref0_pin_i),
      .mode_strap_i(mode_strap_i), .out_mode_i(out_mode_i),
      .cpu_en_i(cpu_en_i), .pci_en_i(pci_en_i),
      .sdr_grp_en_i(sdr_grp_en_i), .misc_en_i(misc_en_i),
      .clk_o(clk_o), .oe_o(oe_o)
   );

   always #5 clk = ~clk;

   // Source clocks with different periods and phases
   always @(posedge clk) begin
      #1;
      cyc_n++;
      cpu_src_i = ((cyc_n >> 1) & 1) != 0;
      pci_src_i = ((cyc_n / 3) % 2) != 0;
      sdr_src_i = (((cyc_n + 1) >> 1) & 1) != 0;
      ref_src_i = ((cyc_n / 5) % 2) != 0;
      usb_src_i = (cyc_n & 1) != 0;
      sio_src_i = ((cyc_n >> 2) & 1) != 0;
   end

   // ---------------- reference model ----------------
   bit m_run[NOUT];
   bit m_q[NOUT];
   bit m_oe[NOUT];
   bit cpu_pipe[$];
   bit pci_pipe[$];

   function automatic bit src_of(int k);
      if (k < 2)  return cpu_src_i;
      if (k < 8)  return pci_src_i;
      if (k < 21) return sdr_src_i;
      if (k < 24) return ref_src_i;
      if (k == 24) return usb_src_i;
      return sio_src_i;
   endfunction

   function automatic bit en_of(int k);
      if (k < 2)   return cpu_en_i[k];
      if (k < 8)   return pci_en_i[k-2];
      if (k == 8)  return 1'b1;
      if (k < 21)  return sdr_grp_en_i[(k-9)/4];
      if (k == 21) return misc_en_i[0] & mode_strap_i;
      return misc_en_i[k-21];
   endfunction

   function automatic string req_of(int k);
      if (k == 1)           return "R3";
      if (k >= 3 && k <= 7) return "R6";
      if (k == 21)          return "R5";
      return "R2";
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NOUT; k++) begin
            m_run[k] = 0; m_q[k] = 0; m_oe[k] = 0;
         end
         cpu_pipe = '{0, 0};
         pci_pipe = '{0, 0};
      end else begin
         bit cs, ps, s;
         cs = cpu_pipe[0];
         ps = pci_pipe[0];
         for (int k = 0; k < NOUT; k++) begin
            bit st;
            s  = src_of(k);
            st = (k == 1) ? cs : ((k >= 3 && k <= 7) ? ps : 1'b0);
            m_q[k] = s & m_run[k];
            if (!s) m_run[k] = en_of(k) & !st;
         end
         for (int k = 0; k < NOUT; k++)
            m_oe[k] = (out_mode_i != 2'b11) && (k != 21 || mode_strap_i);
         void'(cpu_pipe.pop_front());
         cpu_pipe.push_back(!cpu_stop_n_i);
         void'(pci_pipe.pop_front());
         pci_pipe.push_back(!mode_strap_i && !ref0_pin_i);
      end
   end

   // Every-clock comparison against the model
   always @(posedge clk) begin
      #3;
      if (rst_n && !done) begin
         for (int k = 0; k < NOUT; k++) begin
            n_checks++;
            if (clk_o[k] !== m_q[k]) begin
               n_fail++;
               $display("FAIL %s clk_o[%0d] cycle %0d actual %b expected %b",
                        req_of(k), k, cyc_n, clk_o[k], m_q[k]);
            end
            n_checks++;
            if (oe_o[k] !== m_oe[k]) begin
               n_fail++;
               $display("FAIL %s oe_o[%0d] cycle %0d actual %b expected %b",
                        (k == 21) ? "R6" : "R8", k, cyc_n, oe_o[k], m_oe[k]);
            end
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // Count high samples of one output over n cycles
   task automatic count_high(input int n, input int idx, output int highs);
      highs = 0;
      repeat (n) begin
         @(posedge clk);
         #4;
         if (clk_o[idx] === 1'b1) highs++;
      end
      #1;
   endtask

   // ---------------- stimulus ----------------
   initial begin
      int h;
      int h2;
      // R1: reset state
      step(4);
      chk(clk_o == '0, "R1 clk_o in reset", int'(clk_o), 0);
      chk(oe_o == '0, "R1 oe_o in reset", int'(oe_o), 0);
      rst_n = 1'b1;
      step(30);

      // R2 / R5: free outputs and reference pad running
      count_high(24, 0, h);
      chk(h > 0, "R2 free processor clock toggles", h, 12);
      count_high(24, 21, h);
      chk(h > 0, "R5 shared pad drives reference", h, 12);
      chk(oe_o[21] === 1'b1, "R5 shared pad enabled", int'(oe_o[21]), 1);

      // R3 / R4: processor stop at several offsets against the source
      for (int off = 0; off < 4; off++) begin
         step(off + 1);
         cpu_stop_n_i = 1'b0;
         step(8);
         count_high(20, 1, h);
         chk(h == 0, "R3 stopped processor clock rests low", h, 0);
         count_high(20, 0, h2);
         chk(h2 > 0, "R4 free processor clock ignores stop", h2, 10);
         count_high(20, 9, h2);
         chk(h2 > 0, "R4 memory clock ignores stop", h2, 10);
         step(off);
         cpu_stop_n_i = 1'b1;
         step(10);
         count_high(8, 1, h);
         chk(h > 0, "R9 processor clock resumes", h, 4);
      end

      // R5: shared pin low with strap 1 has no stop effect
      ref0_pin_i = 1'b0;
      step(6);
      count_high(24, 3, h);
      chk(h > 0, "R5 bus clock runs with strap 1", h, 12);
      ref0_pin_i = 1'b1;

      // R7: enable bits hold outputs low while pads stay driven
      sdr_grp_en_i = 3'b101;
      pci_en_i     = 6'b111011;
      misc_en_i    = 5'b10111;
      step(8);
      count_high(16, 13, h);
      chk(h == 0, "R7 memory group 1 held low", h, 0);
      count_high(16, 9, h);
      chk(h > 0, "R7 memory group 0 still running", h, 8);
      count_high(16, 4, h);
      chk(h == 0, "R7 bus output 4 held low", h, 0);
      count_high(16, 24, h);
      chk(h == 0, "R7 48 MHz output held low", h, 0);
      chk(oe_o[13] === 1'b1, "R7 disabled pad still driven", int'(oe_o[13]), 1);
      count_high(16, 8, h);
      chk(h > 0, "R7 free memory clock has no enable", h, 8);
      sdr_grp_en_i = '1;
      pci_en_i     = '1;
      misc_en_i    = '1;
      step(10);

      // R8: output modes
      out_mode_i = 2'b11;
      step(2);
      chk(oe_o == '0, "R8 all pads released", int'(oe_o), 0);
      out_mode_i = 2'b10;
      step(2);
      chk(oe_o == '1, "R8 spread mode drives pads", int'(oe_o), (1 << NOUT) - 1);
      out_mode_i = 2'b00;
      step(2);

      // R6: strap 0 after a fresh reset
      rst_n = 1'b0;
      mode_strap_i = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(20);
      chk(oe_o[21] === 1'b0, "R6 shared pad not driven", int'(oe_o[21]), 0);
      count_high(16, 21, h);
      chk(h == 0, "R6 shared pad clock low", h, 0);
      for (int off = 0; off < 3; off++) begin
         step(off + 1);
         ref0_pin_i = 1'b0;
         step(8);
         count_high(24, 5, h);
         chk(h == 0, "R6 bus clock stopped by pad", h, 0);
         count_high(24, 2, h2);
         chk(h2 > 0, "R6 free bus clock keeps running", h2, 12);
         ref0_pin_i = 1'b1;
         step(10);
         count_high(12, 5, h);
         chk(h > 0, "R9 bus clock resumes", h, 6);
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   // Watchdog
   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule